// File: doc/BRIEF.md
# JTAG Test Clock Generator with Returned-Clock Pacing

This block makes the JTAG test clock (TCK) for a shift engine from a single fast system clock. In divider mode, TCK runs at the system clock rate divided by an even ratio taken from a register input, with equal high and low times. In adaptive mode, each TCK edge waits until the target's returned clock (RCLK), after a two-flop synchroniser, has followed the previous edge. This lets a target whose own clock is slow or variable set the pace.

The shift engine holds `tick_req` high while it wants clock edges. `tck_rise` and `tck_fall` are one-cycle strobes that line up with the cycle in which TCK changes, so the engine can sample and drive TDI/TMS on them. A returned clock that never answers raises a sticky `rclk_timeout` flag. The clock is then released anyway, so queued work goes on. Software clears the flag by pulsing `timeout_clr`. Adaptive mode is switched on and off by separate set and clear pulses.

Top module: `tck_gen`

## Requirements
- R1: After reset, `tck`, `tck_rise`, `tck_fall` and `rclk_timeout` are 0, and divider mode is selected.
- R2: In divider mode with an even `div_value` N (2..8190), TCK has a period of N system clocks. The first rising edge comes N/2 cycles after `tick_req` rises from idle.
- R3: Bit 0 of `div_value` is ignored, so an odd value N gives the period of N-1.
- R4: A `div_value` of 0 or 1 acts as 2.
- R5: In divider mode, the high and low times of TCK are each `div_value`/2 cycles (50% duty).
- R6: In adaptive mode, after each TCK edge the next edge happens one cycle after the synchronised RCLK equals TCK. With RCLK looped back through D flops, each half period is D+3 cycles.
- R7: A `adaptive_set` pulse selects adaptive mode and a `adaptive_clr` pulse selects divider mode; if both arrive in the same cycle, clear wins.
- R8: If RCLK has not followed a TCK edge within TIMEOUT cycles, `rclk_timeout` goes to 1 and stays at 1 until cleared.
- R9: A `timeout_clr` pulse clears `rclk_timeout`, unless a new timeout happens in that same cycle.
- R10: A timeout never stalls TCK: the pending edge is taken TIMEOUT cycles after the previous one.
- R11: With `tick_req` low, TCK goes back low at the end of the current high phase and then stays low.
- R12: In divider mode, `rclk_in` has no effect on TCK or on `rclk_timeout`.
- R13: `tck_rise` and `tck_fall` are never high together. `tck_rise` is high exactly in the cycle in which TCK has just gone high, and `tck_fall` exactly in the cycle in which it has just gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_value | input | DIV_W | Divider ratio; bit 0 ignored |
| adaptive_set | input | 1 | Pulse: select adaptive mode |
| adaptive_clr | input | 1 | Pulse: select divider mode |
| rclk_in | input | 1 | Returned clock from target, asynchronous |
| tick_req | input | 1 | Shift engine requests TCK edges |
| timeout_clr | input | 1 | Pulse: clear the timeout flag |
| tck | output | 1 | Test clock |
| tck_rise | output | 1 | Strobe: TCK has just gone high |
| tck_fall | output | 1 | Strobe: TCK has just gone low |
| rclk_timeout | output | 1 | Sticky returned-clock timeout flag |

## Verification
A wrong count in the half-period counter shows on the first TCK phase as a high or low time that differs from `div_value`/2. It is therefore visible within one period of the programmed ratio. A mode bit or synchroniser in the wrong state shows as TCK edges that ignore, or wait for, a looped-back RCLK within a few cycles. A wrong timeout counter shows only after TIMEOUT cycles of silence, as a flag that is set too early or too late, or as a half period longer than TIMEOUT. The bench uses a small TIMEOUT so that this window stays short.

// File: rtl/tck_gen.sv
module tck_gen #(
  parameter int DIV_W   = 13,
  parameter int TIMEOUT = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  input  logic             adaptive_set,
  input  logic             adaptive_clr,
  input  logic             rclk_in,
  input  logic             tick_req,
  input  logic             timeout_clr,
  output logic             tck,
  output logic             tck_rise,
  output logic             tck_fall,
  output logic             rclk_timeout
);
  localparam int HALF_W = DIV_W - 1;
  localparam int TO_W   = $clog2(TIMEOUT) + 1;

  logic              adaptive;
  logic [1:0]        rclk_sync;
  logic [HALF_W-1:0] half_cnt;
  logic [TO_W-1:0]   to_cnt;

  wire              rclk_s   = rclk_sync[1];
  wire [HALF_W-1:0] half_raw = div_value[DIV_W-1:1];
  wire [HALF_W-1:0] half     = (half_raw == '0) ? HALF_W'(1) : half_raw;
  wire              active   = tick_req | tck;
  wire              matched  = (rclk_s == tck);
  wire              to_hit   = adaptive & ~matched & (to_cnt == TO_W'(TIMEOUT - 1));
  wire              div_edge = ~adaptive & active & (half_cnt == half - HALF_W'(1));
  wire              ad_edge  = adaptive & active & (matched | to_hit);
  wire              edge_now = div_edge | ad_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adaptive <= 1'b0;
    end else if (adaptive_clr) begin
      adaptive <= 1'b0;
    end else if (adaptive_set) begin
      adaptive <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rclk_sync <= 2'b00;
    else        rclk_sync <= {rclk_sync[0], rclk_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || adaptive || !active || div_edge) half_cnt <= '0;
    else                                          half_cnt <= half_cnt + HALF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !adaptive || matched || ad_edge) to_cnt <= '0;
    else                                          to_cnt <= to_cnt + TO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tck      <= 1'b0;
      tck_rise <= 1'b0;
      tck_fall <= 1'b0;
    end else begin
      tck_rise <= edge_now & ~tck;
      tck_fall <= edge_now & tck;
      if (edge_now) tck <= ~tck;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rclk_timeout <= 1'b0;
    else if (to_hit)      rclk_timeout <= 1'b1;
    else if (timeout_clr) rclk_timeout <= 1'b0;
  end

  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(tck_rise && tck_fall));
  assert_rise_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tck_rise |-> tck);
  assert_fall_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tck_fall |-> !tck);
  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tck && !tick_req) |=> !tck);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rclk_timeout && !timeout_clr) |=> rclk_timeout);
  assert_div_no_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!adaptive && !rclk_timeout) |=> !rclk_timeout);
  assert_ad_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adaptive && !matched && !to_hit) |=> $stable(tck));
endmodule

// File: tb/test_tck_gen.sv
module test_tck_gen;
  localparam int DIV_W = 13;
  localparam int TO    = 40;

  logic clk = 0, rst_n = 0;
  logic [DIV_W-1:0] div_value = 13'd2;
  logic adaptive_set = 0, adaptive_clr = 0, rclk_in = 0, tick_req = 0, timeout_clr = 0;
  logic tck, tck_rise, tck_fall, rclk_timeout;
  logic loop_en = 0;
  logic lb1;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) lb1 <= tck;
  always_comb rclk_in = loop_en ? lb1 : 1'b0;

  tck_gen #(.DIV_W(DIV_W), .TIMEOUT(TO)) i_tck_gen (
    .clk(clk), .rst_n(rst_n), .div_value(div_value), .adaptive_set(adaptive_set),
    .adaptive_clr(adaptive_clr), .rclk_in(rclk_in), .tick_req(tick_req),
    .timeout_clr(timeout_clr), .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .rclk_timeout(rclk_timeout));

  localparam int NV = 8;
  localparam int DIVS  [NV] = '{2, 3, 10, 11, 0, 1, 64, 200};
  localparam int HALFS [NV] = '{1, 1, 5, 5, 1, 1, 32, 100};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tck_rise && n < 5000);
  endtask

  task automatic measure(output int hi, output int lo);
    int n;
    wait_rise(n);
    hi = 0;
    do begin @(negedge clk); hi++; end while (!tck_fall && hi < 5000);
    wait_rise(lo);
  endtask

  task automatic pulse_set(input bit set_v, input bit clr_v);
    adaptive_set = set_v; adaptive_clr = clr_v;
    @(negedge clk);
    adaptive_set = 0; adaptive_clr = 0;
  endtask

  task automatic to_idle;
    tick_req = 0;
    cyc_n(300);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, lo, n;
    cyc_n(3);
    // R1 reset state
    chk(tck === 0 && tck_rise === 0 && tck_fall === 0, "R1 outputs", tck, 0);
    chk(rclk_timeout === 0, "R1 timeout", rclk_timeout, 0);
    rst_n = 1;
    cyc_n(2);
    // R1: divider mode after reset (div 4 -> half 2)
    div_value = 13'd4; tick_req = 1;
    measure(hi, lo);
    chk(hi == 2 && lo == 2, "R1 divider default", hi, 2);
    to_idle();

    // R2 R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      div_value = DIVS[v][DIV_W-1:0];
      tick_req = 1;
      wait_rise(n);
      chk(n == HALFS[v], "R2 first rise", n, HALFS[v]);
      measure(hi, lo);
      chk(hi == HALFS[v], "R5 high time R3 R4", hi, HALFS[v]);
      chk(hi + lo == 2 * HALFS[v], "R2 period", hi + lo, 2 * HALFS[v]);
      to_idle();
    end

    // R11: drop request while high, tck completes and idles low
    div_value = 13'd20; tick_req = 1;
    wait_rise(n);
    tick_req = 0;
    hi = 0;
    while (tck && hi < 100) begin @(negedge clk); hi++; end
    chk(hi == 10, "R11 finish high phase", hi, 10);
    cyc_n(50);
    chk(tck === 0, "R11 idle low", tck, 0);

    // R12: rclk toggling in divider mode has no effect
    loop_en = 1; div_value = 13'd8; tick_req = 1;
    measure(hi, lo);
    chk(hi == 4 && lo == 4, "R12 divider ignores rclk", hi + lo, 8);
    loop_en = 0;
    cyc_n(TO + 20);
    chk(rclk_timeout === 0, "R12 no timeout in divider", rclk_timeout, 0);
    to_idle();

    // R7 clear wins
    pulse_set(1, 1);
    div_value = 13'd8; tick_req = 1;
    measure(hi, lo);
    chk(hi == 4, "R7 clear wins", hi, 4);
    to_idle();

    // R6 adaptive with loopback D=1 -> half 4
    loop_en = 1;
    pulse_set(1, 0);
    tick_req = 1;
    measure(hi, lo);
    chk(hi == 4 && lo == 4, "R6 adaptive loopback", hi, 4);
    measure(hi, lo);
    chk(hi + lo == 8, "R6 adaptive period", hi + lo, 8);
    chk(rclk_timeout === 0, "R6 no timeout", rclk_timeout, 0);
    to_idle();

    // R8 R10: rclk stuck low
    loop_en = 0;
    tick_req = 1;
    measure(hi, lo);
    chk(hi == TO, "R10 released after timeout", hi, TO);
    chk(lo == 1, "R10 low phase immediate", lo, 1);
    chk(rclk_timeout === 1, "R8 flag set", rclk_timeout, 1);
    to_idle();
    chk(rclk_timeout === 1, "R8 sticky", rclk_timeout, 1);

    // R9 clear
    timeout_clr = 1; @(negedge clk); timeout_clr = 0;
    chk(rclk_timeout === 0, "R9 cleared", rclk_timeout, 0);

    // R7 back to divider mode
    pulse_set(0, 1);
    div_value = 13'd6; tick_req = 1;
    measure(hi, lo);
    chk(hi == 3 && lo == 3, "R7 divider after clr", hi, 3);
    chk(rclk_timeout === 0, "R12 flag stays clear", rclk_timeout, 0);
    tick_req = 0;
    cyc_n(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule